// File: doc/BRIEF.md
# System configuration and keyboard port unit

This unit is a peripheral port block with three 8-bit ports and fixed directions. A processor reaches it through a simple I/O bus with read and write strobes. The first port is an input. It shows either the configuration switch bank or the most recent keyboard scan code, and a bit of the output port chooses between them. The second port is an output latch. It holds the timer-2 gate, the speaker data, the cassette motor control, the enables for RAM parity check and I/O channel check, a keyboard clear bit and the port-A source select. The third port is an input. It joins the memory-expansion switch nibble with live status lines for RAM parity check, I/O channel check, the timer-2 output and cassette data in.

The keyboard side samples an asynchronous clock line and an asynchronous data line. It shifts in scan-code bits least significant first on each falling keyboard clock edge. Once a full code has arrived it latches the code and raises `irq1`, and `irq1` stays high until software sets the clear bit in the output port. The command register slot accepts writes and discards them, so the port directions never change.

The configuration switch byte is passed through unchanged. Bit 0 means a floppy is present, bit 1 means a coprocessor is fitted, bits 3:2 give the memory size, bits 5:4 give the display type and bits 7:6 give the drive count minus one.

Top module: `sysport_unit`

## Requirements
- R1: The unit decodes only the four addresses BASE+0 through BASE+3, where BASE is 0x060 and address bits 1:0 select the port. Whenever `io_rd` is low or the address lies outside that window, `io_rdata` is 0x00.
- R2: A write to BASE+1 loads `io_wdata` into the output latch on the same clock edge. `port_b` always shows the latch, and a read of BASE+1 returns the latched value. No other access changes the latch.
- R3: A read of BASE+0 returns `cfg_sw` when latch bit 7 is 1 and returns the captured scan code when latch bit 7 is 0.
- R4: A read of BASE+2 returns {`par_chk`, `chan_chk`, `tmr2_out`, `cass_in`, `mem_sw[3:0]`}, with `par_chk` in bit 7 and `mem_sw` in bits 3:0.
- R5: Each falling edge of `kbd_clk` shifts the level of `kbd_data` into the code. The first bit received becomes code bit 0.
- R6: On the eighth accepted falling edge the code is latched and `irq1` rises. The rise is visible after the third rising `clk` edge that follows the `kbd_clk` fall.
- R7: While `irq1` is high, further keyboard clock edges are ignored. The latched code and `irq1` do not change until a clear.
- R8: While latch bit 6 is 1, including the edge that writes it, `irq1` is forced low and any partly received code is discarded. The latched code keeps its value.
- R9: Writes to BASE+3, with bit 7 set or clear, change no state. A read of BASE+3 returns the fixed mode word 0x99.
- R10: After reset the output latch is 0x00, `irq1` is low and the scan code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0x00 when not selected |
| kbd_clk | input | 1 | Asynchronous keyboard clock, idle high |
| kbd_data | input | 1 | Asynchronous keyboard serial data |
| cfg_sw | input | 8 | Configuration switch bank |
| mem_sw | input | 4 | Memory-expansion switch nibble |
| cass_in | input | 1 | Cassette data in |
| tmr2_out | input | 1 | Timer 2 output |
| chan_chk | input | 1 | I/O channel check status |
| par_chk | input | 1 | RAM parity check status |
| port_b | output | 8 | Output latch: 0 timer-2 gate, 1 speaker data, 3 cassette motor, 4 parity-check enable, 5 channel-check enable, 6 keyboard clear, 7 switch select |
| irq1 | output | 1 | Scan code ready interrupt request |

## Verification
The bench builds the unit with its default parameters: a base address of 0x060, an 8-bit scan code and a two-stage input synchronizer. Under these values the keyboard path has a three-cycle latency from a `kbd_clk` fall to its effect. The reference model can therefore predict `irq1` and the port-A code to the exact clock. These parameters also bring within reach the cases where whole codes arrive while an interrupt is still pending, where a partial code is cut short by a clear, and where accesses fall just outside the four-address window.

// File: rtl/sysport_pkg.sv
`timescale 1ns/1ps
package sysport_pkg;
    typedef enum logic [1:0] {
        SEL_KBD_SW = 2'd0,
        SEL_OUTLAT = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_MODE   = 2'd3
    } port_sel_e;

    localparam int PB_T2_GATE  = 0;
    localparam int PB_SPK_DATA = 1;
    localparam int PB_CASS_MTR = 3;
    localparam int PB_PAR_EN   = 4;
    localparam int PB_CHK_EN   = 5;
    localparam int PB_KBD_CLR  = 6;
    localparam int PB_SW_SEL   = 7;
endpackage

// File: rtl/sysport_sync.sv
`timescale 1ns/1ps
module sysport_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0][STAGES-1:0] chain_d, chain_q;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            chain_d[i] = {chain_q[i][STAGES-2:0], din[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_out
        assign dout[g] = chain_q[g][STAGES-1];
    end
endmodule

// File: rtl/sysport_kbd.sv
`timescale 1ns/1ps
module sysport_kbd #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kclk_s,
    input  logic              kdat_s,
    input  logic              clr,
    output logic [CODE_W-1:0] code,
    output logic              irq
);
    localparam int CNT_W = $clog2(CODE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);

    typedef struct packed {
        logic              prev;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] sh;
        logic [CODE_W-1:0] code;
        logic              irq;
    } kbd_st_t;

    kbd_st_t st_d, st_q;
    logic    fall;
    logic [CODE_W-1:0] sh_next;

    always_comb begin
        st_d    = st_q;
        fall    = st_q.prev & ~kclk_s;
        sh_next = {kdat_s, st_q.sh[CODE_W-1:1]};
        st_d.prev = kclk_s;
        if (clr) begin
            st_d.cnt = '0;
            st_d.irq = 1'b0;
        end else if (fall && !st_q.irq) begin
            st_d.sh = sh_next;
            if (st_q.cnt == LAST_BIT) begin
                st_d.code = sh_next;
                st_d.irq  = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign irq  = st_q.irq;

    // R6: the request only rises on the last bit of a code
    assert_irq_on_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> ($past(st_q.cnt) == LAST_BIT));
    // R7: a pending request holds, and so does its code
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !clr) |=> st_q.irq);
    assert_code_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> $stable(st_q.code));
    // R8: clear drops the request and the partial count
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!st_q.irq && st_q.cnt == '0));
endmodule

// File: rtl/sysport_bus.sv
`timescale 1ns/1ps
module sysport_bus
    import sysport_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE    = 10'h060,
    parameter logic [7:0]      MODE_WORD = 8'h99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        code,
    input  logic [7:0]        cfg_sw,
    input  logic [3:0]        mem_sw,
    input  logic [3:0]        status,
    output logic [7:0]        rdata,
    output logic [7:0]        lat,
    output logic [7:0]        lat_next
);
    localparam logic [ADDR_W-3:0] BASE_HI = BASE[ADDR_W-1:2];

    typedef struct packed {
        logic [7:0] lat;
    } bus_st_t;

    bus_st_t   st_d, st_q;
    logic      hit;
    port_sel_e sel;
    logic      wr_lat;

    always_comb begin
        hit    = (addr[ADDR_W-1:2] == BASE_HI);
        sel    = port_sel_e'(addr[1:0]);
        wr_lat = wr && hit && (sel == SEL_OUTLAT);
        st_d   = st_q;
        if (wr_lat) st_d.lat = wdata;

        rdata = 8'h00;
        if (rd && hit) begin
            unique case (sel)
                SEL_KBD_SW: rdata = st_q.lat[PB_SW_SEL] ? cfg_sw : code;
                SEL_OUTLAT: rdata = st_q.lat;
                SEL_STATUS: rdata = {status, mem_sw};
                SEL_MODE:   rdata = MODE_WORD;
                default:    rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat      = st_q.lat;
    assign lat_next = st_d.lat;

    // R2: only a port-B write moves the latch
    assert_latch_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hit && addr[1:0] == 2'd1) |=> $stable(st_q.lat));
    // R9: a command-slot write leaves the latch alone
    assert_mode_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit && addr[1:0] == 2'd3) |=> $stable(st_q.lat));
    // R1: idle bus returns zero
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rdata == 8'h00));
endmodule

// File: rtl/sysport_unit.sv
`timescale 1ns/1ps
module sysport_unit
    import sysport_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE        = 10'h060,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              kbd_clk,
    input  logic              kbd_data,
    input  logic [7:0]        cfg_sw,
    input  logic [3:0]        mem_sw,
    input  logic              cass_in,
    input  logic              tmr2_out,
    input  logic              chan_chk,
    input  logic              par_chk,
    output logic [7:0]        port_b,
    output logic              irq1
);
    localparam int CODE_W = 8;

    logic [1:0]        kbd_s;
    logic [CODE_W-1:0] code;
    logic [7:0]        lat_next;

    sysport_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({kbd_data, kbd_clk}),
        .dout (kbd_s)
    );

    sysport_kbd #(.CODE_W(CODE_W)) u_kbd (
        .clk   (clk),
        .rst_n (rst_n),
        .kclk_s(kbd_s[0]),
        .kdat_s(kbd_s[1]),
        .clr   (lat_next[PB_KBD_CLR]),
        .code  (code),
        .irq   (irq1)
    );

    sysport_bus #(.ADDR_W(ADDR_W), .BASE(BASE), .MODE_WORD(8'h99)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (io_addr),
        .rd      (io_rd),
        .wr      (io_wr),
        .wdata   (io_wdata),
        .code    (code),
        .cfg_sw  (cfg_sw),
        .mem_sw  (mem_sw),
        .status  ({par_chk, chan_chk, tmr2_out, cass_in}),
        .rdata   (io_rdata),
        .lat     (port_b),
        .lat_next(lat_next)
    );

    // R8: while the clear bit sits in the latch no request is shown
    assert_clear_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        port_b[PB_KBD_CLR] |-> !irq1);
endmodule

// File: tb/sysport_unit_test.sv
`timescale 1ns/1ps
module sysport_unit_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [9:0] io_addr = '0;
    logic       io_rd = 0, io_wr = 0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       kbd_clk = 1, kbd_data = 1;
    logic [7:0] cfg_sw = 8'h00;
    logic [3:0] mem_sw = 4'h0;
    logic       cass_in = 0, tmr2_out = 0, chan_chk = 0, par_chk = 0;
    logic [7:0] port_b;
    logic       irq1;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sysport_unit uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .kbd_clk(kbd_clk), .kbd_data(kbd_data),
        .cfg_sw(cfg_sw), .mem_sw(mem_sw), .cass_in(cass_in), .tmr2_out(tmr2_out),
        .chan_chk(chan_chk), .par_chk(par_chk), .port_b(port_b), .irq1(irq1)
    );

    // reference model state
    logic [7:0] m_pb = '0;
    logic [7:0] m_code = '0;
    logic       m_irq = 0;
    bit         bits[$];
    int         fall_req = 0;
    int         seen = 0;
    int         cd = 0;
    logic       fall_bit = 0;
    logic       pend_bit = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        if (!io_rd || io_addr[9:2] != 8'h18) return 8'h00;
        case (io_addr[1:0])
            2'd0:    return m_pb[7] ? cfg_sw : m_code;
            2'd1:    return m_pb;
            2'd2:    return {par_chk, chan_chk, tmr2_out, cass_in, mem_sw};
            default: return 8'h99;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pb = '0; m_code = '0; m_irq = 0; bits.delete(); cd = 0; seen = fall_req;
        end else begin
            logic apply_now;
            apply_now = 0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) apply_now = 1;
            end
            if (fall_req != seen) begin
                seen = fall_req; cd = 2; pend_bit = fall_bit;
            end
            if (io_wr && io_addr == 10'h061) m_pb = io_wdata;
            if (m_pb[6]) begin
                bits.delete(); m_irq = 0;
            end else if (apply_now && !m_irq) begin
                bits.push_back(pend_bit);
                if (bits.size() == 8) begin
                    for (int i = 0; i < 8; i++) m_code[i] = bits[i];
                    m_irq = 1;
                    bits.delete();
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R2 port_b", port_b, m_pb);
            chk("R6 irq1", {7'd0, irq1}, {7'd0, m_irq});
            chk(io_addr[1:0] == 2'd0 ? "R3 rdata" : io_addr[1:0] == 2'd2 ? "R4 rdata" : "R1 rdata",
                io_rdata, exp_rdata());
        end
    end

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk); io_wr = 0;
    endtask

    task automatic rd_chk(input logic [9:0] a, input string tag, input logic [7:0] exp);
        @(negedge clk); io_addr = a; io_rd = 1;
        #1 chk(tag, io_rdata, exp);
        @(negedge clk); io_rd = 0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); kbd_data = b;
        repeat (3) @(negedge clk);
        kbd_clk = 0; fall_bit = b; fall_req++;
        repeat (6) @(negedge clk);
        kbd_clk = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_code(input logic [7:0] c);
        for (int i = 0; i < 8; i++) send_bit(c[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset latch", port_b, 8'h00);
        chk("R10 reset irq", {7'd0, irq1}, 8'h00);
        rd_chk(10'h060, "R10 reset code", 8'h00);

        // R3 switch bank through port A
        cfg_sw = 8'h7D;
        wr(10'h061, 8'h80);
        rd_chk(10'h060, "R3 switches", 8'h7D);
        cfg_sw = 8'hA2;
        rd_chk(10'h060, "R3 switches alt", 8'hA2);

        // R2 latch write and readback
        wr(10'h061, 8'hBB);
        rd_chk(10'h061, "R2 readback", 8'hBB);
        chk("R2 pins", port_b, 8'hBB);
        wr(10'h061, 8'h91);
        rd_chk(10'h061, "R2 readback 2", 8'h91);

        // R4 status port
        mem_sw = 4'hA; par_chk = 1; tmr2_out = 1;
        rd_chk(10'h062, "R4 status", 8'hAA);
        mem_sw = 4'h5; par_chk = 0; chan_chk = 1; cass_in = 1; tmr2_out = 0;
        rd_chk(10'h062, "R4 status 2", 8'h55);

        // R1 window edges
        rd_chk(10'h064, "R1 above window", 8'h00);
        rd_chk(10'h05F, "R1 below window", 8'h00);
        rd_chk(10'h160, "R1 alias", 8'h00);
        wr(10'h065, 8'h00);
        chk("R1 outside write", port_b, 8'h91);

        // R9 command slot
        wr(10'h063, 8'h9B);
        wr(10'h063, 8'h05);
        chk("R9 latch kept", port_b, 8'h91);
        rd_chk(10'h063, "R9 mode word", 8'h99);

        // R5 R6 keyboard capture
        wr(10'h061, 8'h00);
        send_code(8'hA5);
        chk("R6 irq raised", {7'd0, irq1}, 8'h01);
        rd_chk(10'h060, "R5 code A5", 8'hA5);

        // R7 extra code ignored while pending
        send_code(8'h3C);
        chk("R7 irq held", {7'd0, irq1}, 8'h01);
        rd_chk(10'h060, "R7 code kept", 8'hA5);

        // R8 clear
        wr(10'h061, 8'h40);
        chk("R8 irq cleared", {7'd0, irq1}, 8'h00);
        rd_chk(10'h060, "R8 code retained", 8'hA5);
        wr(10'h061, 8'h00);
        send_bit(1); send_bit(1); send_bit(1);
        wr(10'h061, 8'h40);
        wr(10'h061, 8'h00);
        send_code(8'h5A);
        chk("R8 partial discarded", {7'd0, irq1}, 8'h01);
        rd_chk(10'h060, "R5 code 5A", 8'h5A);
        wr(10'h061, 8'hC0);
        send_code(8'hFF);
        chk("R8 held clear", {7'd0, irq1}, 8'h00);
        wr(10'h061, 8'h00);
        send_code(8'h01);
        rd_chk(10'h060, "R5 code 01", 8'h01);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule